// File: doc/BRIEF.md
# Delayed-Branch Next-PC Unit

This block owns the program counter of a small 32-bit in-order pipeline whose control transfers have exactly one delay slot. Each cycle it presents a fetch address. The instruction fetched in the previous accepted cycle sits in the resolve stage. The surrounding core decodes that instruction and feeds its control-transfer kind, its operand values and its immediate field back to the block. By then the instruction after the transfer is already being fetched. That delay-slot instruction always executes, and fetch only moves to the target in the cycle after it. Nothing is ever squashed.

The unit decides whether the transfer is taken: a not-equal compare of two operands, or a zero test of one operand. It forms a PC-relative target, a region-absolute target or a register target, and it loads that target into the PC. For a call it also asks for the return address to be written to the link register. A stall input freezes all state. A transfer that is resolved while its own delay slot is the resolving instruction is ignored.

Top module: `npc_delay_slot`

## Requirements
- R1: While reset (`rst_n` low, sampled on the clock edge) is applied, `fetch_addr` equals `BOOT_ADDR` (default 0x0040_0000) and `link_we` is low. No transfer is pending after reset.
- R2: With transfer kind 0 (none) and no stall, `fetch_addr` advances by 4 on every clock edge.
- R3: A transfer is resolved in the cycle after its own address A was fetched. In that cycle `fetch_addr` is A+4, the delay slot. If the transfer is not taken, the fetch after the slot is A+8.
- R4: Kind 1 (branch if not equal) is taken when `opnd_a` differs from `opnd_b`. Its target is A+4 plus the sign-extended `imm_field[15:0]` shifted left by 2, and it is fetched right after the slot.
- R5: Kind 2 (branch if zero) is taken when `opnd_a` equals 0. Its target is the same as for R4.
- R6: Kind 3 (jump) is always taken. Its target is bits [31:28] of A+4 joined to `imm_field[25:0]` and two zero bits.
- R7: Kind 4 (jump and link) goes to the same target as R6. In its resolve cycle it raises `link_we` for exactly one accepted cycle, with `link_idx` = 31 and `link_data` = A+8.
- R8: Kind 5 (jump to register) is always taken and goes to `opnd_a`.
- R9: While `stall` is high, `fetch_addr` and all internal state hold, and `link_we` stays low. When the stall is released, a pending jump-and-link writes its link once.
- R10: Transfer inputs have no effect in the first cycle after reset, because nothing is being resolved yet. They also have no effect in the resolve cycle of a delay slot; fetch then continues sequentially.
- R11: Kind codes 6 and 7 behave as kind 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| stall | input | 1 | Freeze PC and resolve state |
| xfer_kind | input | 3 | Transfer kind of the resolving instruction |
| opnd_a | input | 32 | First operand (compare, zero test, register target) |
| opnd_b | input | 32 | Second operand for the not-equal compare |
| imm_field | input | 26 | Jump index; low 16 bits are the branch offset |
| fetch_addr | output | 32 | Address fetched this cycle |
| link_we | output | 1 | Request to write the return address |
| link_idx | output | 5 | Destination register of the link write |
| link_data | output | 32 | Return address value |

## Verification
The hardest case to reach from the ports is a control transfer that arrives while the delay slot itself is being resolved. It only exists in the cycle right after a taken redirect. The bench builds it directly: it resolves a taken branch, then in the very next cycle drives a jump, and checks that fetch continues after the branch target. The same timing is used for a jump-and-link that is held by a stall across its resolve cycle, to show that the link is written once, on release.

// File: rtl/npc_pkg.sv
// Package npc_pkg
// Shared encodings for the delayed-branch next-PC unit.
// Assumes a 3-bit transfer-kind field; codes above XF_JREG act as no transfer.
package npc_pkg;

    typedef enum logic [2:0] {
        XF_NONE = 3'd0,
        XF_BNE  = 3'd1,
        XF_BZ   = 3'd2,
        XF_JMP  = 3'd3,
        XF_JAL  = 3'd4,
        XF_JREG = 3'd5
    } xfer_e;

    typedef enum logic [1:0] {
        TS_REL = 2'd0,
        TS_ABS = 2'd1,
        TS_REG = 2'd2
    } tsel_e;

endpackage

// File: rtl/npc_resolve.sv
// Module npc_resolve
// Decodes the transfer kind of the resolving instruction and decides
// whether it is taken, which target form applies and whether it links.
// Assumes operands are already forwarded and valid in this cycle.
module npc_resolve
    import npc_pkg::*;
#(
    parameter int unsigned XLEN = 32
) (
    input  logic [2:0]      kind,
    input  logic [XLEN-1:0] opnd_a,
    input  logic [XLEN-1:0] opnd_b,
    output logic            is_xfer,
    output logic            taken,
    output logic            is_link,
    output tsel_e           tsel
);

    // Combinational decode of the kind code and the branch condition.
    always_comb begin
        is_xfer = 1'b1;
        taken   = 1'b0;
        is_link = 1'b0;
        tsel    = TS_REL;
        case (kind)
            XF_BNE:  taken = (opnd_a != opnd_b);
            XF_BZ:   taken = (opnd_a == '0);
            XF_JMP:  begin taken = 1'b1; tsel = TS_ABS; end
            XF_JAL:  begin taken = 1'b1; tsel = TS_ABS; is_link = 1'b1; end
            XF_JREG: begin taken = 1'b1; tsel = TS_REG; end
            default: is_xfer = 1'b0;
        endcase
    end

endmodule

// File: rtl/npc_target.sv
// Module npc_target
// Forms the redirect address from the delay-slot address, the immediate
// field and a register operand. The selection comes from npc_resolve.
// Assumes word-aligned instructions (two zero bits appended).
module npc_target
    import npc_pkg::*;
#(
    parameter int unsigned XLEN  = 32,
    parameter int unsigned OFF_W = 16,
    parameter int unsigned IDX_W = 26
) (
    input  logic [XLEN-1:0]  slot_addr,
    input  logic [IDX_W-1:0] imm,
    input  logic [XLEN-1:0]  reg_val,
    input  tsel_e            tsel,
    output logic [XLEN-1:0]  target
);

    localparam int unsigned SEXT_W = XLEN - OFF_W - 2;
    localparam int unsigned HI_W   = XLEN - IDX_W - 2;

    logic [XLEN-1:0] rel_tgt;
    logic [XLEN-1:0] abs_tgt;
    logic [XLEN-1:0] rel_ofs;

    // Sign-extend the word offset and add it to the slot address.
    always_comb begin
        rel_ofs = {{SEXT_W{imm[OFF_W-1]}}, imm[OFF_W-1:0], 2'b00};
        rel_tgt = slot_addr + rel_ofs;
        abs_tgt = {slot_addr[XLEN-1 -: HI_W], imm, 2'b00};
    end

    // Pick the target form requested by the decoder.
    always_comb begin
        case (tsel)
            TS_ABS:  target = abs_tgt;
            TS_REG:  target = reg_val;
            default: target = rel_tgt;
        endcase
    end

endmodule

// File: rtl/npc_delay_slot.sv
// Module npc_delay_slot (top)
// Program counter with one architectural delay slot. The instruction
// fetched in the previous accepted cycle is resolved now, while its
// delay slot is being fetched. A taken transfer loads the PC for the next
// cycle, so the slot is never squashed. Transfers inside a slot are ignored.
// Assumes the core supplies decoded kind/operands of the resolving
// instruction every cycle, and holds them stable across a stall.
module npc_delay_slot
    import npc_pkg::*;
#(
    parameter int unsigned     XLEN      = 32,
    parameter int unsigned     OFF_W     = 16,
    parameter int unsigned     IDX_W     = 26,
    parameter int unsigned     REG_W     = 5,
    parameter int unsigned     LINK_REG  = 31,
    parameter logic [XLEN-1:0] BOOT_ADDR = 32'h0040_0000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stall,
    input  logic [2:0]       xfer_kind,
    input  logic [XLEN-1:0]  opnd_a,
    input  logic [XLEN-1:0]  opnd_b,
    input  logic [IDX_W-1:0] imm_field,
    output logic [XLEN-1:0]  fetch_addr,
    output logic             link_we,
    output logic [REG_W-1:0] link_idx,
    output logic [XLEN-1:0]  link_data
);

    localparam logic [XLEN-1:0] INSN_B = XLEN'(4);

    logic [XLEN-1:0] pc_q;
    logic [XLEN-1:0] res_pc_q;
    logic            res_vld_q;
    logic            in_slot_q;

    logic            is_xfer;
    logic            taken;
    logic            is_link;
    tsel_e           tsel;
    logic [XLEN-1:0] slot_addr;
    logic [XLEN-1:0] tgt;
    logic            act;
    logic            redirect;
    logic [XLEN-1:0] pc_nxt;

    npc_resolve #(.XLEN(XLEN)) u_resolve (
        .kind    (xfer_kind),
        .opnd_a  (opnd_a),
        .opnd_b  (opnd_b),
        .is_xfer (is_xfer),
        .taken   (taken),
        .is_link (is_link),
        .tsel    (tsel)
    );

    npc_target #(.XLEN(XLEN), .OFF_W(OFF_W), .IDX_W(IDX_W)) u_target (
        .slot_addr (slot_addr),
        .imm       (imm_field),
        .reg_val   (opnd_a),
        .tsel      (tsel),
        .target    (tgt)
    );

    // Next-PC selection: redirect only for a real, non-slot, taken transfer.
    always_comb begin
        slot_addr = res_pc_q + INSN_B;
        act       = res_vld_q && !in_slot_q;
        redirect  = act && taken;
        pc_nxt    = redirect ? tgt : (pc_q + INSN_B);
    end

    // PC, resolve-stage address and slot marker advance on accepted cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q      <= BOOT_ADDR;
            res_pc_q  <= '0;
            res_vld_q <= 1'b0;
            in_slot_q <= 1'b0;
        end else if (!stall) begin
            pc_q      <= pc_nxt;
            res_pc_q  <= pc_q;
            res_vld_q <= 1'b1;
            in_slot_q <= act && is_xfer;
        end
    end

    // Output drive: fetch address and single-cycle link request.
    always_comb begin
        fetch_addr = pc_q;
        link_we    = rst_n && !stall && act && is_link;
        link_idx   = REG_W'(LINK_REG);
        link_data  = res_pc_q + (INSN_B << 1);
    end

    // ---------------- assertions ----------------
    p_stall_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> fetch_addr == $past(fetch_addr));

    p_stall_nolink_r9: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> !link_we);

    p_seq_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && !redirect) |=> fetch_addr == $past(fetch_addr) + INSN_B);

    p_slot_fetched_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (act && is_xfer) |-> fetch_addr == res_pc_q + INSN_B);

    p_redirect_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && redirect) |=> fetch_addr == $past(tgt));

    p_link_once_r7: assert property (@(posedge clk) disable iff (!rst_n)
        link_we |=> !link_we);

    p_link_value_r7: assert property (@(posedge clk) disable iff (!rst_n)
        link_we |-> (link_data == fetch_addr + INSN_B) && (link_idx == REG_W'(LINK_REG)));

    p_slot_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && in_slot_q) |=> fetch_addr == $past(fetch_addr) + INSN_B);

endmodule

// File: tb/npc_delay_slot_bench.sv
`timescale 1ns/1ps
module npc_delay_slot_bench;

    localparam logic [31:0] BOOT = 32'h0040_0000;

    typedef struct packed {
        logic [2:0]  kind;
        logic [31:0] a;
        logic [31:0] b;
        logic [25:0] imm;
        logic        tk;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t TBL [NV] = '{
        '{3'd1, 32'd5,          32'd5, 26'h0000010, 1'b0},  // R4 equal -> not taken
        '{3'd1, 32'd5,          32'd6, 26'h0000010, 1'b1},  // R4 differ -> taken fwd
        '{3'd1, 32'd1,          32'd0, 26'h000FFF0, 1'b1},  // R4 negative offset
        '{3'd2, 32'd0,          32'd9, 26'h0000008, 1'b1},  // R5 zero -> taken
        '{3'd2, 32'h8000_0000,  32'd0, 26'h0000008, 1'b0},  // R5 nonzero -> not taken
        '{3'd3, 32'd0,          32'd0, 26'h0100040, 1'b1},  // R6 jump
        '{3'd4, 32'd0,          32'd0, 26'h0100080, 1'b1},  // R7 jump and link
        '{3'd5, 32'h0040_0100,  32'd0, 26'h0000000, 1'b1},  // R8 register target
        '{3'd6, 32'd0,          32'd0, 26'h0000004, 1'b0},  // R11 code 6
        '{3'd7, 32'd0,          32'd0, 26'h0000004, 1'b0}   // R11 code 7
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic        stall;
    logic [2:0]  xfer_kind;
    logic [31:0] opnd_a;
    logic [31:0] opnd_b;
    logic [25:0] imm_field;
    logic [31:0] fetch_addr;
    logic        link_we;
    logic [4:0]  link_idx;
    logic [31:0] link_data;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    npc_delay_slot u_npc_delay_slot (
        .clk(clk), .rst_n(rst_n), .stall(stall), .xfer_kind(xfer_kind),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .imm_field(imm_field),
        .fetch_addr(fetch_addr), .link_we(link_we), .link_idx(link_idx),
        .link_data(link_data)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic drive(input logic [2:0] k, input logic [31:0] a,
                         input logic [31:0] b, input logic [25:0] im);
        xfer_kind = k; opnd_a = a; opnd_b = b; imm_field = im;
        #0.5;
    endtask

    // Model of the fetch address that follows the delay slot.
    function automatic logic [31:0] after_slot(input logic [31:0] A, input vec_t v);
        logic [31:0] s;
        s = A + 32'd4;
        if (!v.tk) return s + 32'd4;
        case (v.kind)
            3'd1, 3'd2: return s + {{14{v.imm[15]}}, v.imm[15:0], 2'b00};
            3'd3, 3'd4: return {s[31:28], v.imm, 2'b00};
            default:    return v.a;
        endcase
    endfunction

    initial begin
        #100000;
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] A;
        logic [31:0] T;
        rst_n = 1'b0; stall = 1'b0;
        drive(3'd0, '0, '0, '0);
        @(negedge clk);
        tick(); tick();
        chk("R1 reset fetch", fetch_addr, BOOT);
        chk("R1 reset link", {31'd0, link_we}, 32'd0);
        rst_n = 1'b1;
        // R10: first cycle after reset has no resolving instruction
        drive(3'd5, 32'h0000_1000, 32'd0, 26'd0);
        chk("R10 no link at start", {31'd0, link_we}, 32'd0);
        tick();
        chk("R10 ignored at start", fetch_addr, BOOT + 32'd4);
        drive(3'd0, '0, '0, '0);
        tick();
        chk("R2 sequential", fetch_addr, BOOT + 32'd8);

        // Table walk
        for (int i = 0; i < NV; i++) begin
            A = fetch_addr;
            tick();
            chk("R3 slot fetched", fetch_addr, A + 32'd4);
            drive(TBL[i].kind, TBL[i].a, TBL[i].b, TBL[i].imm);
            if (TBL[i].kind == 3'd4) begin
                chk("R7 link we", {31'd0, link_we}, 32'd1);
                chk("R7 link idx", {27'd0, link_idx}, 32'd31);
                chk("R7 link data", link_data, A + 32'd8);
            end else begin
                chk("R7 no link", {31'd0, link_we}, 32'd0);
            end
            tick();
            drive(3'd0, '0, '0, '0);
            T = after_slot(A, TBL[i]);
            chk("R4-R8/R11 after slot", fetch_addr, T);  // R4 R5 R6 R8 R11
            tick();
            chk("R2 continue", fetch_addr, T + 32'd4);
        end

        // R9: stall over a jump-and-link resolve cycle
        A = fetch_addr;
        tick();
        stall = 1'b1;
        drive(3'd4, 32'd0, 32'd0, 26'h0000200);
        chk("R9 no link in stall", {31'd0, link_we}, 32'd0);
        tick();
        chk("R9 hold fetch", fetch_addr, A + 32'd4);
        chk("R9 no link still", {31'd0, link_we}, 32'd0);
        tick();
        chk("R9 hold fetch 2", fetch_addr, A + 32'd4);
        stall = 1'b0;
        #0.5;
        chk("R9 link on release", {31'd0, link_we}, 32'd1);
        chk("R9 link data", link_data, A + 32'd8);
        tick();
        drive(3'd0, '0, '0, '0);
        chk("R9 link once", {31'd0, link_we}, 32'd0);
        chk("R9 target", fetch_addr, {A[31:28] , 26'h0000200, 2'b00});
        tick();

        // R10: transfer driven during the delay slot's resolve cycle
        A = fetch_addr;
        tick();
        drive(3'd1, 32'd1, 32'd2, 26'h0000004);
        tick();
        T = A + 32'd4 + 32'd16;
        chk("R10 branch target", fetch_addr, T);
        drive(3'd3, 32'd0, 32'd0, 26'h0000000);
        chk("R10 no link in slot", {31'd0, link_we}, 32'd0);
        tick();
        drive(3'd0, '0, '0, '0);
        chk("R10 slot transfer ignored", fetch_addr, T + 32'd4);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule